// File: doc/BRIEF.md
# Circuit Misroute Detection Unit

This block sits at one input port of a circuit-switched network router. Each input port holds a flit buffer and has at most one realized circuit, which is the reserved path this port currently forwards on. The realized circuit carries the destination and request identifier of the request that reserved it. When a header flit reaches the front of the buffer, the unit compares those two tags with the header's own fields. The comparison is purely combinational and runs in the cycle the flit crosses the switch, so forwarding costs no extra hop cycle. The match result gates the valid sent to the next port. A misrouted header is therefore dropped downstream, stays in the local buffer, and is not dequeued.

A mismatch can be seen before the upstream router asks for the stale circuit to be removed. In that case, the next cycle the unit sends a one-flit remove message tagged with the stale circuit's fields and pulses a release to the reservation buffer. It then remembers to discard the next remove request that comes from upstream. The reservation buffer is modelled only by ports. After the release it realizes the next circuit, and the held header then goes out normally.

Top module: `misroute_check_port`

## Requirements
- R1: After reset, fwd_valid, deq, rm_valid and circ_release are 0, and no upstream remove is being ignored.
- R2: A header flit (head_valid=1, head_is_hdr=1) whose destination (head_flit bits [3:0]) and request id (bits [7:4]) both equal circ_dst and circ_rid, with circ_valid=1, raises fwd_valid and deq in the same cycle, and fwd_flit equals head_flit.
- R3: A header whose destination or request id differs from the realized circuit gives fwd_valid=0 and deq=0 in that cycle.
- R4: Once a header has been forwarded, the body flits of that message (head_is_hdr=0) are forwarded without comparison, up to and including the flit with head_is_tail=1. A body flit with no message open is not forwarded.
- R5: A mismatch seen in a cycle with no unignored up_remove produces rm_valid=1 in the next cycle only. In that cycle rm_dst and rm_rid hold the circuit tags from the mismatch cycle, circ_release=1 and fwd_valid=0.
- R6: After such an early removal, the next up_remove pulse produces no circ_release, and a later pulse is honoured again.
- R7: An up_remove pulse with no ignore pending raises circ_release in the same cycle.
- R8: If a mismatch coincides with an honoured up_remove, no remove message is sent, and the following up_remove is not ignored.
- R9: Once the reservation buffer presents a matching circuit after a removal, the held header is forwarded in that same cycle.
- R10: With circ_valid=0 nothing is forwarded and no remove message is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Flit buffer holds a head flit |
| head_is_hdr | input | 1 | Head flit is a message header |
| head_is_tail | input | 1 | Head flit is the last of its message |
| head_flit | input | FLIT_W (16) | Head flit; destination [3:0], request id [7:4] |
| circ_valid | input | 1 | A circuit is realized at this port |
| circ_dst | input | DST_W (4) | Destination tag of the realized circuit |
| circ_rid | input | ID_W (4) | Request id tag of the realized circuit |
| up_remove | input | 1 | Remove-circuit request from the upstream router |
| fwd_valid | output | 1 | Data valid toward the next input port |
| fwd_flit | output | FLIT_W (16) | Flit sent across the switch |
| deq | output | 1 | Pop the head flit from the flit buffer |
| rm_valid | output | 1 | One-flit remove-conflicting-circuit message valid |
| rm_dst | output | DST_W (4) | Destination tag of the circuit to remove |
| rm_rid | output | ID_W (4) | Request id tag of the circuit to remove |
| circ_release | output | 1 | Tell the reservation buffer to drop the realized circuit |

## Verification
The comparison is tried with a header that matches fully, one that is wrong only in destination, and one that is wrong only in request id. This shows that both fields take part in the check and that either one alone blocks forwarding. A multi-flit message followed by a stray body flit separates tag-free body forwarding from open-message tracking. Two mismatch sequences, one with the upstream remove arriving late and one with it arriving in the mismatch cycle, separate the early-remove path and its ignore flag from the plain upstream release. A final case with no realized circuit confirms that nothing moves.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   typedef enum logic [0:0] {
      MRC_RUN  = 1'b0,
      MRC_KILL = 1'b1
   } mrc_phase_e;
endpackage

// File: rtl/mrc_compare.sv
module mrc_compare #(
   parameter int DST_W    = 4,
   parameter int ID_W     = 4,
   parameter bit CHECK_ID = 1'b1
) (
   input  logic [DST_W-1:0] hdr_dst,
   input  logic [ID_W-1:0]  hdr_rid,
   input  logic [DST_W-1:0] cir_dst,
   input  logic [ID_W-1:0]  cir_rid,
   output logic             same
);
   logic dst_eq;
   assign dst_eq = (hdr_dst == cir_dst);

   generate
      if (CHECK_ID) begin : g_both
         assign same = dst_eq & (hdr_rid == cir_rid);
      end else begin : g_dst_only
         logic [ID_W-1:0] unused_rid;
         assign unused_rid = hdr_rid ^ cir_rid;
         assign same = dst_eq;
      end
   endgenerate
endmodule

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
   import mrc_pkg::*;
#(
   parameter int DST_W = 4,
   parameter int ID_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hv,
   input  logic             is_hdr,
   input  logic             is_tail,
   input  logic             cv,
   input  logic             same,
   input  logic             up_remove,
   input  logic [DST_W-1:0] cir_dst,
   input  logic [ID_W-1:0]  cir_rid,
   output logic             fwd,
   output logic             rm_out,
   output logic [DST_W-1:0] rm_dst,
   output logic [ID_W-1:0]  rm_rid,
   output logic             release_o,
   output logic             ign_o
);
   mrc_phase_e phase_q, phase_d;
   logic ign_q, ign_d;
   logic open_q, open_d;
   logic hdr_ok, body_ok, mis, up_take, early, killing;

   assign killing  = (phase_q == MRC_KILL);
   assign hdr_ok   = hv & cv & is_hdr & same & ~killing;
   assign body_ok  = hv & cv & ~is_hdr & open_q & ~killing;
   assign fwd      = hdr_ok | body_ok;
   assign mis      = hv & cv & is_hdr & ~same & ~killing;
   assign up_take  = up_remove & ~ign_q;
   assign early    = mis & ~up_take;
   assign release_o = killing | up_take;
   assign rm_out   = killing;
   assign ign_o    = ign_q;

   always_comb begin
      phase_d = early ? MRC_KILL : MRC_RUN;
      if (killing)        ign_d = ~up_take;
      else if (up_remove) ign_d = 1'b0;
      else                ign_d = ign_q;
      if (release_o)      open_d = 1'b0;
      else if (fwd)       open_d = ~is_tail;
      else                open_d = open_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= MRC_RUN;
         ign_q   <= 1'b0;
         open_q  <= 1'b0;
         rm_dst  <= '0;
         rm_rid  <= '0;
      end else begin
         phase_q <= phase_d;
         ign_q   <= ign_d;
         open_q  <= open_d;
         if (early) begin
            rm_dst <= cir_dst;
            rm_rid <= cir_rid;
         end
      end
   end
endmodule

// File: rtl/misroute_check_port.sv
module misroute_check_port #(
   parameter int FLIT_W   = 16,
   parameter int DST_W    = 4,
   parameter int ID_W     = 4,
   parameter int DST_LSB  = 0,
   parameter int ID_LSB   = 4,
   parameter bit CHECK_ID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic              head_is_hdr,
   input  logic              head_is_tail,
   input  logic [FLIT_W-1:0] head_flit,
   input  logic              circ_valid,
   input  logic [DST_W-1:0]  circ_dst,
   input  logic [ID_W-1:0]   circ_rid,
   input  logic              up_remove,
   output logic              fwd_valid,
   output logic [FLIT_W-1:0] fwd_flit,
   output logic              deq,
   output logic              rm_valid,
   output logic [DST_W-1:0]  rm_dst,
   output logic [ID_W-1:0]   rm_rid,
   output logic              circ_release
);
   localparam int DST_MSB = DST_LSB + DST_W - 1;
   localparam int ID_MSB  = ID_LSB + ID_W - 1;

   generate
      if (DST_W < 1 || ID_W < 1) begin : g_bad_w
         $error("tag widths must be positive");
      end
      if (DST_MSB >= FLIT_W || ID_MSB >= FLIT_W) begin : g_bad_fit
         $error("tag fields must fit in the flit");
      end
      if (!(DST_MSB < ID_LSB || ID_MSB < DST_LSB)) begin : g_bad_ovl
         $error("tag fields must not overlap");
      end
   endgenerate

   logic [DST_W-1:0] hdr_dst;
   logic [ID_W-1:0]  hdr_rid;
   logic             same;
   logic             ign_pend;

   assign hdr_dst  = head_flit[DST_MSB:DST_LSB];
   assign hdr_rid  = head_flit[ID_MSB:ID_LSB];
   assign fwd_flit = head_flit;
   assign deq      = fwd_valid;

   mrc_compare #(.DST_W(DST_W), .ID_W(ID_W), .CHECK_ID(CHECK_ID)) u_cmp (
      .hdr_dst (hdr_dst),
      .hdr_rid (hdr_rid),
      .cir_dst (circ_dst),
      .cir_rid (circ_rid),
      .same    (same)
   );

   mrc_ctrl #(.DST_W(DST_W), .ID_W(ID_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hv        (head_valid),
      .is_hdr    (head_is_hdr),
      .is_tail   (head_is_tail),
      .cv        (circ_valid),
      .same      (same),
      .up_remove (up_remove),
      .cir_dst   (circ_dst),
      .cir_rid   (circ_rid),
      .fwd       (fwd_valid),
      .rm_out    (rm_valid),
      .rm_dst    (rm_dst),
      .rm_rid    (rm_rid),
      .release_o (circ_release),
      .ign_o     (ign_pend)
   );
endmodule

// File: rtl/misroute_check_port_chk.sv
module misroute_check_port_chk #(
   parameter int FLIT_W  = 16,
   parameter int DST_W   = 4,
   parameter int ID_W    = 4,
   parameter int DST_LSB = 0,
   parameter int ID_LSB  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              head_valid,
   input logic              head_is_hdr,
   input logic [FLIT_W-1:0] head_flit,
   input logic              circ_valid,
   input logic [DST_W-1:0]  circ_dst,
   input logic [ID_W-1:0]   circ_rid,
   input logic              up_remove,
   input logic              fwd_valid,
   input logic              rm_valid,
   input logic              circ_release,
   input logic              ign_pend
);
   logic hdr_bad;
   assign hdr_bad = head_valid & head_is_hdr & circ_valid &
      ((head_flit[DST_LSB +: DST_W] != circ_dst) || (head_flit[ID_LSB +: ID_W] != circ_rid));

   p_mis_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_bad |-> !fwd_valid);
   p_rm_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_bad && !up_remove && !rm_valid |=> rm_valid);
   p_rm_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rm_valid |=> !rm_valid);
   p_rm_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rm_valid |-> circ_release && !fwd_valid);
   p_ignore_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rm_valid && !up_remove ##1 up_remove |-> !circ_release);
   p_up_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      up_remove && !ign_pend |-> circ_release);
   p_no_circ_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !circ_valid |-> !fwd_valid);
endmodule

bind misroute_check_port misroute_check_port_chk #(
   .FLIT_W(FLIT_W), .DST_W(DST_W), .ID_W(ID_W), .DST_LSB(DST_LSB), .ID_LSB(ID_LSB)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .head_valid   (head_valid),
   .head_is_hdr  (head_is_hdr),
   .head_flit    (head_flit),
   .circ_valid   (circ_valid),
   .circ_dst     (circ_dst),
   .circ_rid     (circ_rid),
   .up_remove    (up_remove),
   .fwd_valid    (fwd_valid),
   .rm_valid     (rm_valid),
   .circ_release (circ_release),
   .ign_pend     (ign_pend)
);

// File: tb/misroute_check_port_test.sv
module misroute_check_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        head_valid = 1'b0, head_is_hdr = 1'b0, head_is_tail = 1'b0;
   logic [15:0] head_flit = '0;
   logic        circ_valid = 1'b0;
   logic [3:0]  circ_dst = '0, circ_rid = '0;
   logic        up_remove = 1'b0;
   logic        fwd_valid, deq, rm_valid, circ_release;
   logic [15:0] fwd_flit;
   logic [3:0]  rm_dst, rm_rid;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   misroute_check_port uut (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_is_hdr(head_is_hdr),
      .head_is_tail(head_is_tail), .head_flit(head_flit), .circ_valid(circ_valid),
      .circ_dst(circ_dst), .circ_rid(circ_rid), .up_remove(up_remove),
      .fwd_valid(fwd_valid), .fwd_flit(fwd_flit), .deq(deq), .rm_valid(rm_valid),
      .rm_dst(rm_dst), .rm_rid(rm_rid), .circ_release(circ_release)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive after negedge, settle, then check combinational outputs of this cycle
   task automatic drive(input logic hv, input logic hdr, input logic tl,
                        input logic [3:0] d, input logic [3:0] r,
                        input logic cv, input logic [3:0] cd, input logic [3:0] cr,
                        input logic up);
      @(negedge clk);
      head_valid = hv; head_is_hdr = hdr; head_is_tail = tl;
      head_flit = {8'hA5, r, d};
      circ_valid = cv; circ_dst = cd; circ_rid = cr; up_remove = up;
      #2;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      idle();
      chk("R1 fwd", {15'd0, fwd_valid}, 16'd0);
      chk("R1 deq", {15'd0, deq}, 16'd0);
      chk("R1 rm", {15'd0, rm_valid}, 16'd0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R1 no ignore after reset", {15'd0, circ_release}, 16'd1);
   endtask

   task automatic t_match_msg();
      drive(1, 1, 0, 4'd5, 4'd3, 1, 4'd5, 4'd3, 0);
      chk("R2 fwd", {15'd0, fwd_valid}, 16'd1);
      chk("R2 deq", {15'd0, deq}, 16'd1);
      chk("R2 flit", fwd_flit, 16'hA535);
      drive(1, 0, 0, 4'd0, 4'd0, 1, 4'd5, 4'd3, 0);
      chk("R4 body", {15'd0, fwd_valid}, 16'd1);
      drive(1, 0, 1, 4'd0, 4'd0, 1, 4'd5, 4'd3, 0);
      chk("R4 tail", {15'd0, fwd_valid}, 16'd1);
      drive(1, 0, 0, 4'd0, 4'd0, 1, 4'd5, 4'd3, 0);
      chk("R4 stray body", {15'd0, fwd_valid}, 16'd0);
      chk("R4 stray rm", {15'd0, rm_valid}, 16'd0);
   endtask

   task automatic t_mis_dst();
      drive(1, 1, 1, 4'd6, 4'd3, 1, 4'd5, 4'd3, 0);
      chk("R3 dst fwd", {15'd0, fwd_valid}, 16'd0);
      chk("R3 dst deq", {15'd0, deq}, 16'd0);
      chk("R3 no rm yet", {15'd0, rm_valid}, 16'd0);
      drive(1, 1, 1, 4'd6, 4'd3, 1, 4'd5, 4'd3, 0);
      chk("R5 rm", {15'd0, rm_valid}, 16'd1);
      chk("R5 rm tags", {8'd0, rm_rid, rm_dst}, 16'h0035);
      chk("R5 release", {15'd0, circ_release}, 16'd1);
      chk("R5 fwd held", {15'd0, fwd_valid}, 16'd0);
      drive(1, 1, 1, 4'd6, 4'd3, 1, 4'd6, 4'd3, 0);
      chk("R9 resume fwd", {15'd0, fwd_valid}, 16'd1);
      chk("R5 rm one cycle", {15'd0, rm_valid}, 16'd0);
      drive(0, 0, 0, 0, 0, 1, 4'd6, 4'd3, 1);
      chk("R6 ignored", {15'd0, circ_release}, 16'd0);
      drive(0, 0, 0, 0, 0, 1, 4'd6, 4'd3, 1);
      chk("R6 R7 honoured", {15'd0, circ_release}, 16'd1);
   endtask

   task automatic t_mis_id();
      drive(1, 1, 1, 4'd5, 4'd9, 1, 4'd5, 4'd3, 0);
      chk("R3 id fwd", {15'd0, fwd_valid}, 16'd0);
      drive(1, 1, 1, 4'd5, 4'd9, 1, 4'd5, 4'd3, 0);
      chk("R5 id rm", {15'd0, rm_valid}, 16'd1);
      chk("R5 id tags", {8'd0, rm_rid, rm_dst}, 16'h0035);
      idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R6 id ignored", {15'd0, circ_release}, 16'd0);
   endtask

   task automatic t_concurrent();
      drive(1, 1, 1, 4'd7, 4'd1, 1, 4'd2, 4'd1, 1);
      chk("R8 fwd", {15'd0, fwd_valid}, 16'd0);
      chk("R8 release", {15'd0, circ_release}, 16'd1);
      drive(1, 1, 1, 4'd7, 4'd1, 1, 4'd7, 4'd1, 0);
      chk("R8 no rm", {15'd0, rm_valid}, 16'd0);
      chk("R8 R9 fwd", {15'd0, fwd_valid}, 16'd1);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R8 no ignore", {15'd0, circ_release}, 16'd1);
   endtask

   task automatic t_nocirc();
      drive(1, 1, 1, 4'd4, 4'd4, 0, 4'd1, 4'd1, 0);
      chk("R10 fwd", {15'd0, fwd_valid}, 16'd0);
      idle();
      chk("R10 rm", {15'd0, rm_valid}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_match_msg();
      t_mis_dst();
      t_mis_id();
      t_concurrent();
      t_nocirc();
      idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule